// File: doc/BRIEF.md
# Cross-Memory Match Distance Engine

This block holds two word memories. Each has its own write path and a registered read port. When started, it walks the first memory one address at a time, from address zero to the last address. For each outer word it reads the word once and holds it. It then sweeps the second memory upward from address zero, one location per clock, until a stored word equals the held one. It reports the signed offset between the two addresses, outer minus inner, with a one-cycle valid strobe. If the sweep reaches the last location without an equal word, it raises a one-cycle no-match strobe instead.

Exactly one result is produced per outer address, in ascending outer order. The result stream therefore needs no index: the n-th event belongs to outer address n. The memories can be loaded only while the engine is idle. A done flag stays up after the last outer address has been handled, until the next start.

Top module: `mds_engine`

## Requirements
- R1: After reset, `busy`, `done`, `distValid` and `noMatch` are all low.
- R2: A `start` pulse while idle raises `busy` on the next cycle and clears `done`. Processing begins at outer address 0 and the first result belongs to outer address 0.
- R3: For each outer address, the reported match is the lowest second-memory address holding a word equal to the first-memory word.
- R4: `distance` is (outer address − inner address) as an (ADDR_W+1)-bit two's-complement value, so both negative and positive offsets are exact, from −(2^ADDR_W−1) to +(2^ADDR_W−1).
- R5: Each outer address yields exactly one event, in ascending outer order. The event is a single-cycle `distValid` pulse on a match, or a single-cycle `noMatch` pulse when no second-memory word is equal. The two strobes are never high together.
- R6: Work per outer address takes j+3 cycles for a match at inner address j, and 2^ADDR_W+2 cycles for no match. This covers one load cycle, the sweep cycles and one advance cycle.
- R7: After the last outer address, `done` rises, `busy` falls, and `done` stays high until the next accepted `start`.
- R8: A write is presented on `wrEn`, `wrSel`, `wrAddr` and `wrData`. `wrSel`=0 selects the first memory and `wrSel`=1 the second. The write takes effect only while `busy` is low; writes presented while busy leave both memories unchanged.
- R9: A `start` pulse while busy is ignored: the running pass neither restarts nor changes its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass at outer address 0 (honoured when idle) |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | Write target: 0 first memory, 1 second memory |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | Last pass finished; held until next start |
| distValid | output | 1 | One-cycle strobe: `distance` holds a new result |
| distance | output | ADDR_W+1 | Signed outer-minus-inner address offset |
| noMatch | output | 1 | One-cycle strobe: current outer word absent from second memory |

## Verification
A pipelined inner address that slips by one cycle against the registered read data shows up at the ports. The reported offset is then wrong by one on every match, and a miss is flagged one location early or late. Both are visible at the first result, which arrives a few cycles after start. Controller faults are caught at the result stream within one outer pass: a lost or doubled event, a skipped outer address, or a wrong per-address cycle count shifts every later event index and moves the cycle at which `done` rises. A write that slips through while busy corrupts stored words. It surfaces when the same contents are searched again and the offsets differ from the values computed from the loaded pattern.

// File: rtl/mds_pkg.sv
package mds_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic restart;   // start accepted: outer and inner addresses to zero
    logic loadWord;  // read and hold the current first-memory word
    logic sweep;     // compare held word with swept second-memory word
    logic advance;   // move to the next outer address
    logic writeOk;   // engine idle, memory writes allowed
  } mdsStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SWEEP,
    ST_ADVANCE
  } mdsState_t;

endpackage

// File: rtl/mds_mem.sv
module mds_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[wrAddr] <= wrData;
    if (rdEn) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/mds_ctrl.sv
module mds_ctrl
  import mds_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       hit,
  input  logic       miss,
  input  logic       lastOuter,
  output mdsStrobe_t strb,
  output logic       busy,
  output logic       done
);
  mdsState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (start) stateNext = ST_LOAD;
      ST_LOAD:    stateNext = ST_SWEEP;
      ST_SWEEP:   if (hit || miss) stateNext = ST_ADVANCE;
      ST_ADVANCE: stateNext = lastOuter ? ST_IDLE : ST_LOAD;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.restart  = (state == ST_IDLE) && start;
    strb.loadWord = (state == ST_LOAD);
    strb.sweep    = (state == ST_SWEEP);
    strb.advance  = (state == ST_ADVANCE);
    strb.writeOk  = (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.restart) done <= 1'b0;
      else if (strb.advance && lastOuter) done <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  // R7
  doneIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> state == ST_IDLE);

  // R2
  loadEntry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> ($past(state) == ST_IDLE || $past(state) == ST_ADVANCE));

  // R6
  advanceFromSweep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADVANCE) |-> $past(state) == ST_SWEEP);

  // R9
  noRestart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SWEEP && start) |=> (state == ST_SWEEP || state == ST_ADVANCE));
endmodule

// File: rtl/mds_datapath.sv
module mds_datapath
  import mds_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mdsStrobe_t               strb,
  input  logic                     wrEn,
  input  logic                     wrSel,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic                     hit,
  output logic                     miss,
  output logic                     lastOuter,
  output logic                     distValid,
  output logic signed [ADDR_W:0]   distance,
  output logic                     noMatch
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam int NMEM = 2;

  logic [ADDR_W-1:0] outerAddr, innerAddr, innerQ;
  logic [DATA_W-1:0] rdData [NMEM];
  logic              memWe  [NMEM];
  logic              memRdEn[NMEM];
  logic [ADDR_W-1:0] memRdAddr[NMEM];

  always_comb begin
    memWe[0]     = wrEn && strb.writeOk && !wrSel;
    memWe[1]     = wrEn && strb.writeOk && wrSel;
    memRdEn[0]   = strb.loadWord;   // outer word read once, then held
    memRdEn[1]   = 1'b1;
    memRdAddr[0] = outerAddr;
    memRdAddr[1] = innerAddr;
  end

  for (genvar g = 0; g < NMEM; g++) begin : gMem
    mds_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uMem (
      .clk   (clk),
      .we    (memWe[g]),
      .wrAddr(wrAddr),
      .wrData(wrData),
      .rdEn  (memRdEn[g]),
      .rdAddr(memRdAddr[g]),
      .rdData(rdData[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outerAddr <= '0;
      innerAddr <= '0;
      innerQ    <= '0;
    end else begin
      innerQ <= innerAddr;  // address belonging to next cycle's read data
      if (strb.restart) outerAddr <= '0;
      else if (strb.advance) outerAddr <= outerAddr + 1'b1;
      if (strb.restart || strb.advance) innerAddr <= '0;
      else if (strb.loadWord || strb.sweep) innerAddr <= innerAddr + 1'b1;
    end
  end

  logic wordsEqual;
  assign wordsEqual = (rdData[0] == rdData[1]);
  assign hit        = strb.sweep && wordsEqual;
  assign miss       = strb.sweep && !wordsEqual && (innerQ == LAST);
  assign lastOuter  = (outerAddr == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      distValid <= 1'b0;
      noMatch   <= 1'b0;
      distance  <= '0;
    end else begin
      distValid <= hit;
      noMatch   <= miss;
      if (hit) distance <= $signed({1'b0, outerAddr}) - $signed({1'b0, innerQ});
    end
  end

  // R5
  validPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    distValid |=> !distValid);

  // R5
  missAtEnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    noMatch |-> $past(innerQ) == LAST);

  // R5
  oneEvent_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({distValid, noMatch}));

  // R3
  hitFromSweep_chk: assert property (@(posedge clk) disable iff (!rstN)
    distValid |-> $past(strb.sweep));
endmodule

// File: rtl/mds_engine.sv
module mds_engine
  import mds_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   wrEn,
  input  logic                   wrSel,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  output logic                   busy,
  output logic                   done,
  output logic                   distValid,
  output logic signed [ADDR_W:0] distance,
  output logic                   noMatch
);
  mdsStrobe_t strb;
  logic hit, miss, lastOuter;

  mds_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .hit      (hit),
    .miss     (miss),
    .lastOuter(lastOuter),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  mds_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .hit      (hit),
    .miss     (miss),
    .lastOuter(lastOuter),
    .distValid(distValid),
    .distance (distance),
    .noMatch  (noMatch)
  );
endmodule

// File: tb/mds_engine_test.sv
module mds_engine_test;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, wrEn = 1'b0, wrSel = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic busy, done, distValid, noMatch;
  logic signed [AW:0] distance;

  always #10 clk = ~clk;  // 50 MHz

  mds_engine #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn), .wrSel(wrSel),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .done(done),
    .distValid(distValid), .distance(distance), .noMatch(noMatch)
  );

  int checks = 0, fails = 0;
  int m1 [N];
  int m2 [N];
  int evKind [64];
  int evDist [64];
  int evCount = 0;
  int bothHigh = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (distValid && noMatch) bothHigh++;
    if ((distValid || noMatch) && evCount < 64) begin
      evKind[evCount] = distValid ? 1 : 0;
      evDist[evCount] = int'(distance);
      evCount++;
    end
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic writeWord(input bit sel, input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = AW'(a); wrData = DW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadPattern(input int kind);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: begin m1[i] = i + 10;   m2[i] = 17 - i; end
        1: begin m1[i] = i;        m2[i] = i + 100; end
        2: begin m1[i] = i % 4;    m2[i] = i / 2; end
        3: begin m1[i] = (i*3)%11; m2[i] = (i*5)%11; end
        default: begin m1[i] = 255; m2[i] = (i == N-1) ? 255 : i; end
      endcase
    end
    for (int i = 0; i < N; i++) begin
      writeWord(1'b0, i, m1[i]);
      writeWord(1'b1, i, m2[i]);
    end
  endtask

  // Run one pass and compare the event stream with the loaded model (R2..R9)
  task automatic runPass(input string name, input bit disturb);
    int expCycles, cycles, j;
    expCycles = 1;
    for (int i = 0; i < N; i++) begin
      j = -1;
      for (int k = N-1; k >= 0; k--) if (m2[k] == m1[i]) j = k;
      expCycles += (j < 0) ? (N + 2) : (j + 3);
    end
    evCount = 0; bothHigh = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cycles = 1;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(done == 1'b0, "R2 done cleared by start", done, 0);
    while (!done && cycles < 1000) begin
      @(negedge clk);
      cycles++;
      wrEn = 1'b0; start = 1'b0;
      if (disturb && cycles >= 3 && cycles < 3 + 2*N) begin
        wrEn = 1'b1; wrSel = cycles[0]; wrAddr = AW'(cycles); wrData = 8'hEE;  // R8
      end
      if (disturb && (cycles == 5 || cycles == 20)) start = 1'b1;  // R9
    end
    wrEn = 1'b0; start = 1'b0;
    chk(cycles == expCycles, {"R6 pass length ", name}, cycles, expCycles);
    chk(evCount == N, {"R5 event count ", name}, evCount, N);
    chk(bothHigh == 0, "R5 strobes exclusive", bothHigh, 0);
    for (int i = 0; i < N && i < evCount; i++) begin
      j = -1;
      for (int k = N-1; k >= 0; k--) if (m2[k] == m1[i]) j = k;
      if (j < 0) chk(evKind[i] == 0, {"R5 no-match event ", name}, evKind[i], 0);
      else begin
        chk(evKind[i] == 1, {"R3 match event ", name}, evKind[i], 1);
        chk(evDist[i] == i - j, {"R4 distance ", name}, evDist[i], i - j);
      end
    end
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R7 done held", done, 1);
    chk(busy == 1'b0, "R7 busy low", busy, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done at reset", {busy, done}, 0);
    chk(distValid == 0 && noMatch == 0, "R1 strobes at reset", {distValid, noMatch}, 0);
    rstN = 1'b1;
    loadPattern(0); runPass("mirror", 1'b0);      // R4 negative and positive
    loadPattern(1); runPass("all-miss", 1'b0);    // R5 misses
    loadPattern(2); runPass("duplicates", 1'b1);  // R3 first occurrence, R8/R9 disturbance
    runPass("recheck", 1'b0);                     // R8 contents unchanged by busy writes
    loadPattern(3); runPass("mixed", 1'b0);       // R8 idle writes take effect
    loadPattern(4); runPass("last-slot", 1'b0);   // R6 longest match
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule